// File: doc/BRIEF.md
# UART Receive FIFO with Fill Trigger

This block buffers received characters for the receive side of a UART. A deserializer pushes bytes in, the host pops them out oldest first, and status outputs report whether data is waiting, how many bytes are held, whether a programmable fill threshold has been reached, and whether a byte was lost. The pop side is show-ahead: the oldest byte is always present on the read data output while data-ready is high.

A single write-only control byte configures the block. One bit turns queueing on or off. Two bits pick one of four thresholds. One bit empties the receive queue, and another bit produces a one-cycle flush pulse for the transmit queue kept elsewhere. With queueing off, the block acts as a single holding register. A new byte replaces the held one, and a byte that replaces an unread byte counts as lost.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, queueing is disabled, the threshold code is 00, level is 0, and data_ready, trig_hit, overrun and tx_flush are all 0.
- R2: With queueing enabled (control bit 0 = 1), up to 16 bytes are held and popped in arrival order. pop_data shows the oldest byte, level counts the bytes held, and data_ready is high exactly when level is nonzero. Outputs change on the clock edge that takes the push or pop.
- R3: trig_hit is high when level is at least the threshold. With queueing enabled, control bits 7:6 set the threshold: 00 means 1, 01 means 4, 10 means 8, 11 means 14. With queueing disabled, the threshold is 1.
- R4: A control write with bit 1 = 1 empties the receive queue, so level is 0 after that edge.
- R5: tx_flush is high for exactly the one cycle after a control write that has bit 2 = 1 or that changes bit 0. Otherwise it is low.
- R6: A control write whose bit 0 differs from the current enable state empties the receive queue and switches the mode.
- R7: Control bits 5:3 have no effect on any output.
- R8: A push that finds no free place is dropped and sets overrun. Overrun stays set until a cycle with stat_rd high and no new loss. If a loss and stat_rd occur in the same cycle, overrun is set.
- R9: With queueing disabled, a push stores its byte as the only content (level 1). If a held byte was not popped in the same cycle, overrun is set.
- R10: In a cycle where a control write empties the queue, any push and pop in that same cycle are discarded.
- R11: A pop with level 0 changes nothing. With queueing enabled and the queue full, a push and a pop in the same cycle are both taken, with no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte value |
| push | input | 1 | Received byte valid |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Host read of the oldest byte |
| stat_rd | input | 1 | Host status read; clears overrun |
| pop_data | output | 8 | Oldest held byte |
| data_ready | output | 1 | At least one byte held |
| level | output | 5 | Number of bytes held |
| trig_hit | output | 1 | Level at or above threshold |
| overrun | output | 1 | Sticky byte-lost flag |
| tx_flush | output | 1 | One-cycle transmit queue flush pulse |

## Verification
Directed runs fill the queue to exactly 16 and push once more. They pop from an empty queue, and they push and pop together at full. These runs separate correct full and empty boundaries from counts that are off by one. A sweep over the four threshold codes at levels just below and at each threshold separates the non-linear decode from a linear one. In seeded random traffic, mode switches, flush commands and reserved-bit writes land between pushes and pops. This traffic shows whether ordering, the holding-register overwrite and the same-cycle precedence of flushes over data stay correct.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_data,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             stat_rd,
  output logic [WIDTH-1:0] pop_data,
  output logic             data_ready,
  output logic [LW-1:0]    level,
  output logic             trig_hit,
  output logic             overrun,
  output logic             tx_flush
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [LW-1:0]    cnt, thr_lvl;
  logic             fifo_en, ovr, txf;
  logic [1:0]       thr_sel;

  wire en_change = ctl_wr && (ctl_data[0] != fifo_en);
  wire flush_now = ctl_wr && (ctl_data[1] || en_change);
  wire is_full   = (cnt == LW'(DEPTH));
  wire do_pop    = !flush_now && pop && (cnt != '0);
  wire do_push   = !flush_now && push && (fifo_en ? (!is_full || do_pop) : 1'b1);
  wire drop      = !flush_now && push &&
                   (fifo_en ? (is_full && !do_pop) : (cnt != '0 && !pop));

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (thr_sel)
      2'b00:   thr_lvl = LW'(1);
      2'b01:   thr_lvl = LW'(4);
      2'b10:   thr_lvl = LW'(8);
      default: thr_lvl = LW'(14);
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[fifo_en ? wr_ptr : rd_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      thr_sel <= 2'b00;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      ovr     <= 1'b0;
      txf     <= 1'b0;
    end else begin
      txf <= ctl_wr && (ctl_data[2] || en_change);
      if (ctl_wr) begin
        fifo_en <= ctl_data[0];
        thr_sel <= ctl_data[7:6];
      end
      if (flush_now) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        cnt    <= '0;
      end else if (fifo_en) begin
        if (do_push) wr_ptr <= nxt(wr_ptr);
        if (do_pop)  rd_ptr <= nxt(rd_ptr);
        cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end else begin
        if (do_push)     cnt <= LW'(1);
        else if (do_pop) cnt <= '0;
      end
      if (drop)         ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
    end
  end

  assign pop_data   = mem[rd_ptr];
  assign data_ready = (cnt != '0);
  assign level      = cnt;
  assign trig_hit   = (cnt >= (fifo_en ? thr_lvl : LW'(1)));
  assign overrun    = ovr;
  assign tx_flush   = txf;

endmodule

module rx_fifo_trig_chk #(
  parameter int DEPTH = 16,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [7:0]    ctl_data,
  input logic          push,
  input logic          pop,
  input logic          stat_rd,
  input logic          en,
  input logic [LW-1:0] level,
  input logic          data_ready,
  input logic          trig_hit,
  input logic          overrun,
  input logic          tx_flush
);

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R4
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[1] |=> level == '0);

  // R5
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[2] |=> tx_flush);

  // R5
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> !tx_flush);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !ctl_wr && push && !pop && level == LW'(DEPTH) |=> overrun);

  // R8
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !push |=> !overrun);

  // R9
  single_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> level <= LW'(1));

  // R3
  trig_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready);

endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .push(push), .pop(pop), .stat_rd(stat_rd), .en(fifo_en),
  .level(level), .data_ready(data_ready), .trig_hit(trig_hit),
  .overrun(overrun), .tx_flush(tx_flush)
);

// File: tb/rx_fifo_trig_tb.sv
module rx_fifo_trig_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, push = 0, pop = 0, stat_rd = 0;
  logic [7:0] ctl_data = 0, push_data = 0, pop_data;
  logic data_ready, trig_hit, overrun, tx_flush;
  logic [4:0] level;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  bit m_en = 0, m_ovr = 0, m_tx = 0;
  bit [1:0] m_thr = 0;

  always #2 clk = ~clk;

  rx_fifo_trig u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .push(push), .push_data(push_data), .pop(pop), .stat_rd(stat_rd),
    .pop_data(pop_data), .data_ready(data_ready), .level(level),
    .trig_hit(trig_hit), .overrun(overrun), .tx_flush(tx_flush)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int thr_of(bit en, bit [1:0] t);
    if (!en) return 1;
    case (t)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model(bit cw, logic [7:0] cd, bit ps, logic [7:0] pd, bit pp, bit sr);
    bit chg = cw && (cd[0] != m_en);
    bit fl = cw && (cd[1] || chg);
    bit lost = 0;
    m_tx = cw && (cd[2] || chg);
    if (cw) begin m_en = cd[0]; m_thr = cd[7:6]; end
    if (fl) q.delete();
    else if (m_en) begin
      bit popd = pp && q.size() > 0;
      if (popd) void'(q.pop_front());
      if (ps) begin
        if (q.size() < 16) q.push_back(pd);
        else lost = 1;
      end
    end else begin
      if (ps) begin
        if (q.size() == 1 && !pp) lost = 1;
        q.delete(); q.push_back(pd);
      end else if (pp) q.delete();
    end
    if (lost) m_ovr = 1;
    else if (sr) m_ovr = 0;
  endtask

  task automatic check_all(string tag);
    chk(tag, "level", int'(level), q.size());
    chk(tag, "data_ready", int'(data_ready), int'(q.size() > 0));
    chk(tag, "trig_hit", int'(trig_hit), int'(q.size() >= thr_of(m_en, m_thr)));
    chk(tag, "overrun", int'(overrun), int'(m_ovr));
    chk(tag, "tx_flush", int'(tx_flush), int'(m_tx));
    if (q.size() > 0) chk(tag, "pop_data", int'(pop_data), int'(q[0]));
  endtask

  task automatic step(string tag, bit cw, logic [7:0] cd, bit ps, logic [7:0] pd, bit pp, bit sr);
    @(negedge clk);
    ctl_wr = cw; ctl_data = cd; push = ps; push_data = pd; pop = pp; stat_rd = sr;
    model(cw, cd, ps, pd, pp, sr);
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "level", int'(level), 0);
    chk("R1", "data_ready", int'(data_ready), 0);
    chk("R1", "trig_hit", int'(trig_hit), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "tx_flush", int'(tx_flush), 0);
    @(negedge clk); rst_n = 1;

    // R9 single register mode
    step("R9", 0, 0, 1, 8'h11, 0, 0);
    step("R9", 0, 0, 1, 8'h22, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 1, 8'h33, 1, 0);
    step("R11", 0, 0, 0, 0, 1, 0);
    step("R11", 0, 0, 0, 0, 1, 0);
    // R6 enable, R5 pulse on change, threshold 14
    step("R6", 1, 8'hC1, 1, 8'h44, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step("R3", 0, 0, 1, 8'(i + 8'h50), 0, 0);
    step("R8", 0, 0, 1, 8'hEE, 0, 0);
    step("R11", 0, 0, 1, 8'h77, 1, 0);
    step("R8", 0, 0, 1, 8'h78, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 1);
    // R7 reserved bits; R3 other codes
    step("R7", 1, 8'h39, 0, 0, 0, 0);
    step("R3", 1, 8'h81, 0, 0, 0, 0);
    step("R3", 1, 8'h41, 0, 0, 0, 0);
    // R10 flush discards same-cycle push and pop
    step("R10", 1, 8'h03, 1, 8'h99, 1, 0);
    step("R4", 0, 0, 1, 8'hA1, 0, 0);
    step("R5", 1, 8'h05, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R4", 1, 8'h03, 0, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 0);
    for (int k = 0; k < 5; k++) step("R3", 0, 0, 1, 8'(k), 0, 0);

    for (int n = 0; n < 4000; n++) begin
      bit cw = ($urandom % 40) == 0;
      logic [7:0] cd = 8'($urandom);
      bit ps = ($urandom % 100) < 60;
      bit pp = ($urandom % 100) < 45;
      bit sr = ($urandom % 10) == 0;
      if (cw && cd[0] == 0 && ($urandom % 3) != 0) cd[0] = 1;
      step("R2", cw, cd, ps, 8'($urandom), pp, sr);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule